// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It uses two component predictors. The first is a per-address table of 2-bit saturating counters. The second is a table of 2-bit counters indexed by the branch address XORed with a global history of recent outcomes. A third table of 2-bit counters, the chooser, decides for each branch which component's guess appears at the output. The output also reports which component supplied the guess.

The fetch side presents a PC on the lookup port. It receives the prediction in the same cycle, because every read is combinational from the stored state. When a branch resolves, the back end presents its PC and real outcome on the update port. The block then does three things:
- It re-derives both component guesses from its current state.
- It trains both component counters.
- It moves the chooser only when exactly one component was right.

The global history shifts in the outcome after the tables have been indexed for that update.

Top module: `tourney_predictor`

## Requirements
- R1: While reset is asserted and right after it, every counter in all three tables holds 1 and the global history is zero. Every lookup therefore returns pred_taken=0 and pred_src=0.
- R2: The local table is indexed by PC[11:2], and PC bits outside [11:2] have no effect on any lookup or update. A component guesses taken when its counter is 2 or 3.
- R3: The global-component index is PC[11:2] XOR the 10-bit global history.
- R4: The chooser entry is indexed by PC[11:2]. Values 0 and 1 select the local component (pred_src=0), values 2 and 3 select the global component (pred_src=1), and pred_taken is the selected component's guess.
- R5: Every update trains both component counters with the actual outcome. A counter goes up by one on taken and down by one on not taken, saturating at 3 and at 0.
- R6: When both components were right, or both were wrong, the chooser entry is left unchanged.
- R7: When only the global guess was right, the chooser goes up by one, saturating at 3. When only the local guess was right, it goes down by one, saturating at 0. From 0 it takes two global-only outcomes to select the global component.
- R8: After an update, the global history shifts left by one with the outcome (taken=1) entering at bit 0. The update's own indexing uses the history value before the shift.
- R9: A lookup in the same cycle as an update sees the state before that update. The update becomes visible to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Branch address being looked up |
| pred_taken | output | 1 | Final direction guess, 1 = taken |
| pred_src | output | 1 | Component that supplied the guess: 0 local, 1 global |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch, 1 = taken |

## Verification
The assertions assume the following about the inputs:
- Updates arrive one per cycle at most.
- upd_taken is meaningful only when upd_valid is high.
- The chooser-hold property is only meaningful while the lookup address stays put across the two cycles it spans.

The stimulus changes its inputs only on the falling edge and holds upd_valid low outside update steps. Many steps repeat a lookup address, so that property actually fires. Training sequences reuse a small set of indices so that counters reach both saturation limits and the history folds into aliased global entries.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_TOP = 2'd3;
  localparam ctr2_t CTR_BOT = 2'd0;

  typedef enum logic {
    SRC_LOCAL  = 1'b0,
    SRC_GLOBAL = 1'b1
  } tp_src_e;

  // saturating one-step move of a 2-bit counter
  function automatic ctr2_t sat_step(ctr2_t v, logic up);
    ctr2_t r;
    if (up) r = (v == CTR_TOP) ? v : v + 2'd1;
    else    r = (v == CTR_BOT) ? v : v - 2'd1;
    return r;
  endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tp_pkg::*;
#(
  parameter int    IDX_W   = 10,
  parameter ctr2_t RST_VAL = 2'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr,
  input  logic [IDX_W-1:0] up_idx,
  output ctr2_t            up_ctr,
  input  logic             wr_en,
  input  logic             wr_up
);

  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem [DEPTH];
  ctr2_t nxt_ctr;

  assign rd_ctr = mem[rd_idx];
  assign up_ctr = mem[up_idx];

  always_comb begin
    nxt_ctr = sat_step(up_ctr, wr_up);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
    end else if (wr_en) begin
      mem[up_idx] <= nxt_ctr;
    end
  end

  assert_sat_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && up_ctr == CTR_TOP) |=> (mem[$past(up_idx)] == CTR_TOP));

  assert_sat_bot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && up_ctr == CTR_BOT) |=> (mem[$past(up_idx)] == CTR_BOT));

  // R6: an entry not written keeps its value
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (mem[$past(up_idx)] == $past(up_ctr)));

endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] hist
);

  logic [W-1:0] hist_q, hist_d;

  always_comb begin
    hist_d = hist_q;
    if (shift_en) hist_d = {hist_q[W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist = hist_q;

  assert_hist_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist));

  assert_hist_insert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (hist[0] == $past(bit_in)));

endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
  import tp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 10,
  parameter int IDX_LSB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_taken,
  output logic            pred_src,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  localparam ctr2_t WEAK_LO = 2'd1;

  logic [IDX_W-1:0] lk_idx, up_idx, ghr;
  logic [IDX_W-1:0] lk_gidx, up_gidx;
  ctr2_t loc_lk, loc_up, gsh_lk, gsh_up, ch_lk, ch_up;
  logic loc_ok, glb_ok, ch_wr;
  tp_src_e src_sel;
  logic unused_pc_bits;

  assign lk_idx  = lk_pc[IDX_LSB +: IDX_W];
  assign up_idx  = upd_pc[IDX_LSB +: IDX_W];
  assign lk_gidx = lk_idx ^ ghr;
  assign up_gidx = up_idx ^ ghr;

  assign unused_pc_bits = ^{lk_pc[PC_W-1:IDX_LSB+IDX_W], lk_pc[IDX_LSB-1:0],
                            upd_pc[PC_W-1:IDX_LSB+IDX_W], upd_pc[IDX_LSB-1:0],
                            ch_up[0]};

  tp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(WEAK_LO)) u_local (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_ctr(loc_lk),
    .up_idx(up_idx), .up_ctr(loc_up),
    .wr_en(upd_valid), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(WEAK_LO)) u_gshare (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_gidx), .rd_ctr(gsh_lk),
    .up_idx(up_gidx), .up_ctr(gsh_up),
    .wr_en(upd_valid), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(WEAK_LO)) u_chooser (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_ctr(ch_lk),
    .up_idx(up_idx), .up_ctr(ch_up),
    .wr_en(ch_wr), .wr_up(glb_ok)
  );

  tp_ghist #(.W(IDX_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .shift_en(upd_valid), .bit_in(upd_taken),
    .hist(ghr)
  );

  // correctness of each component for the resolving branch
  always_comb begin
    loc_ok = (loc_up[1] == upd_taken);
    glb_ok = (gsh_up[1] == upd_taken);
    ch_wr  = upd_valid && (loc_ok != glb_ok);
  end

  // final selection
  always_comb begin
    src_sel    = ch_lk[1] ? SRC_GLOBAL : SRC_LOCAL;
    pred_src   = src_sel;
    pred_taken = (src_sel == SRC_GLOBAL) ? gsh_lk[1] : loc_lk[1];
  end

  // R6: agreement in correctness leaves the looked-up chooser entry alone
  assert_chooser_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (loc_ok == glb_ok) && (up_idx == lk_idx))
      |=> (!$stable(lk_pc) || $stable(ch_lk)));

  // R7: a global-only win never lowers the chooser
  assert_chooser_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && glb_ok && !loc_ok && (up_idx == lk_idx))
      |=> (!$stable(lk_pc) || (ch_lk >= $past(ch_lk))));

endmodule

// File: tb/tb_tourney_predictor.sv
`timescale 1ns/1ps
module tb_tourney_predictor;

  logic        clk;
  logic        rst_n;
  logic [31:0] lk_pc, upd_pc;
  logic        upd_valid, upd_taken;
  logic        pred_taken, pred_src;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  tourney_predictor dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
    .pred_taken(pred_taken), .pred_src(pred_src),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // model state built from the requirements
  int mloc [1024];
  int mgsh [1024];
  int mch  [1024];
  int mghr;

  function automatic int sat(int v, bit up);
    if (up) return (v == 3) ? 3 : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic mreset();
    for (int i = 0; i < 1024; i++) begin
      mloc[i] = 1; mgsh[i] = 1; mch[i] = 1;
    end
    mghr = 0;
  endtask

  function automatic int ix(logic [31:0] pc);
    return int'(pc[11:2]);
  endfunction

  task automatic mpredict(input logic [31:0] pc, output bit p, output bit s);
    int i;
    i = ix(pc);
    s = (mch[i] >= 2);
    p = s ? (mgsh[i ^ mghr] >= 2) : (mloc[i] >= 2);
  endtask

  task automatic mupdate(input logic [31:0] pc, input bit t);
    int  i, g;
    bit  lo, go;
    i  = ix(pc);
    g  = i ^ mghr;
    lo = ((mloc[i] >= 2) == t);
    go = ((mgsh[g] >= 2) == t);
    mloc[i] = sat(mloc[i], t);
    mgsh[g] = sat(mgsh[g], t);
    if (lo != go) mch[i] = sat(mch[i], go);
    mghr = ((mghr << 1) | int'(t)) & 1023;
  endtask

  task automatic check(input bit ap, input bit as, input bit ep, input bit es, input string tag);
    checks++;
    if (ap !== ep || as !== es) begin
      errors++;
      $display("FAIL %s: pred=%0b src=%0b expected pred=%0b src=%0b", tag, ap, as, ep, es);
    end
  endtask

  // lookup only, compared against hand-computed values
  task automatic peek(input logic [31:0] pc, input bit ep, input bit es, input string tag);
    @(negedge clk);
    upd_valid = 0; lk_pc = pc;
    #1 check(pred_taken, pred_src, ep, es, tag);
  endtask

  // lookup and update in the same cycle, compared against the model
  task automatic step(input logic [31:0] lpc, input logic [31:0] upc, input bit t, input string tag);
    bit ep, es;
    @(negedge clk);
    lk_pc = lpc; upd_pc = upc; upd_valid = 1; upd_taken = t;
    #1;
    mpredict(lpc, ep, es);
    check(pred_taken, pred_src, ep, es, tag);
    @(posedge clk);
    mupdate(upc, t);
    @(negedge clk);
    upd_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; upd_valid = 0;
    mreset();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // stimulus table: {pc index, taken}
  localparam int NV = 16;
  localparam logic [10:0] VEC [NV] = '{
    {10'd3, 1'b1}, {10'd3, 1'b1}, {10'd3, 1'b1}, {10'd3, 1'b1},
    {10'd7, 1'b0}, {10'd7, 1'b0}, {10'd3, 1'b0}, {10'd7, 1'b1},
    {10'd1, 1'b1}, {10'd0, 1'b1}, {10'd1, 1'b0}, {10'd0, 1'b1},
    {10'd3, 1'b1}, {10'd7, 1'b1}, {10'd1, 1'b1}, {10'd0, 1'b0}
  };

  initial begin
    rst_n = 0; upd_valid = 0; upd_taken = 0; lk_pc = '0; upd_pc = '0;
    mreset();
    // R1: outputs during reset
    #3 lk_pc = 32'h0000_0ABC;
    #1 check(pred_taken, pred_src, 1'b0, 1'b0, "R1 in reset");
    repeat (2) @(negedge clk);
    rst_n = 1;
    peek(32'h0000_0000, 1'b0, 1'b0, "R1 after reset");
    peek(32'hFFFF_FFFC, 1'b0, 1'b0, "R1 after reset");

    // R6: both wrong at index 1; R8 history becomes 1
    step(32'h4, 32'h4, 1'b1, "R6 R9 both wrong");
    // R3: global entry 0^1=1 now 2, chooser still local
    peek(32'h0, 1'b0, 1'b0, "R4 local selected");
    // R7: only global right at index 0 -> chooser 2
    step(32'h0, 32'h0, 1'b1, "R7 R9 global only");
    // history = 3, global index 3 holds 1 -> not taken from global
    peek(32'h0, 1'b0, 1'b1, "R7 R3 switched to global");
    // R2: upper PC bits ignored
    peek(32'hABC0_0000, 1'b0, 1'b1, "R2 upper bits ignored");
    peek(32'h0000_0003, 1'b0, 1'b1, "R2 low bits ignored");

    // table walk
    do_reset();
    for (int v = 0; v < NV; v++) begin
      logic [31:0] pc;
      pc = {20'd0, VEC[v][10:1], 2'b00};
      step(pc, pc, VEC[v][0], "R3 R4 R5 R8 table");
    end

    // R5 saturation and R7 two-step behavior at one index
    for (int k = 0; k < 8; k++) step(32'h10, 32'h10, 1'b1, "R5 saturate high");
    for (int k = 0; k < 8; k++) step(32'h10, 32'h10, 1'b0, "R5 saturate low");
    for (int k = 0; k < 12; k++) step(32'h10, 32'h10, k[0], "R6 R7 alternating");

    // pseudo-random mixed traffic over a small index set
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int n = 0; n < 1500; n++) begin
        logic [31:0] lpc, upc;
        lf  = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        upc = {lf[15:12], 22'd0, lf[3:0], 2'b00};
        lpc = lf[4] ? upc : {28'd0, lf[7:6], 2'b00};
        step(lpc, upc, lf[8] | lf[9], "R2 R5 R6 R7 R8 R9 mixed");
      end
    end

    // R1: reset mid-run returns everything to weak not-taken, local
    @(negedge clk);
    rst_n = 0;
    #1 check(pred_taken, pred_src, 1'b0, 1'b0, "R1 async reset");
    mreset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    peek(32'h10, 1'b0, 1'b0, "R1 after second reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule